// File: doc/BRIEF.md
# Memory Ordering Queue with Barriers

This block keeps every in-flight memory operation of a core in age order and decides, each cycle, which of them may go to the memory pipeline under a relaxed ordering model. Dispatch allocates one entry per load, store, load barrier or store barrier. Each entry gets a slot number that later identifies it. The block presents one issue-ok bit per slot and accepts a completion for a slot once that operation has executed.

Entries leave strictly from the oldest end. The oldest entry is released when it has completed. A barrier is released as soon as it becomes the oldest entry, because by then every older operation has finished. Loads and load barriers count against the load capacity; stores and store barriers count against the store capacity. A full flag per side tells dispatch to hold. A global mode input selects the optimistic policy, in which loads do not wait for older stores. Aliasing is not computed here. A per-load flag given at allocation tells the block that the load is known not to overlap older stores.

Top module: `mem_order_queue`

## Requirements
- R1: After reset no slot is issue-ok, both full flags are low and the next allocation slot is 0.
- R2: An allocation is accepted only when its side is below capacity. `alloc_kind` encodes 0 = load, 1 = store, 2 = load barrier, 3 = store barrier. Bit 0 selects the store side and bit 1 marks a barrier. Accepted entries take slots 0,1,...,DEPTH-1 in turn and then wrap to 0. A rejected allocation changes nothing. A full flag is high exactly when its side holds its capacity.
- R3: A store is issue-ok only when every older load and store has completed and no older store barrier remains.
- R4: A load is issue-ok regardless of older loads, but never while an older load barrier remains.
- R5: With `noalias_mode` high a load ignores older stores. With it low, a load waits for every older store to complete unless the load was allocated with `alloc_noalias` high.
- R6: Barriers are never issue-ok. A load barrier does not hold stores back, and a store barrier does not hold loads back. A barrier that is the oldest entry is released at the next clock edge.
- R7: A completion for an issue-ok slot marks it completed, which clears its issue-ok bit. A completion for any other slot, or an out-of-range slot, is ignored.
- R8: At each clock edge the oldest entry is released if it had completed before that edge or is a barrier. At most one entry is released per edge. Its capacity is returned, and an allocation in the same cycle is still honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| noalias_mode | input | 1 | Optimistic policy: loads ignore older stores |
| alloc_valid | input | 1 | Allocation request from dispatch |
| alloc_kind | input | 2 | Entry kind (see R2) |
| alloc_noalias | input | 1 | Load known not to overlap older stores |
| alloc_slot | output | IW | Slot the next accepted allocation takes |
| lq_full | output | 1 | Load side at capacity |
| sq_full | output | 1 | Store side at capacity |
| cmpl_valid | input | 1 | Execute-complete notification |
| cmpl_slot | input | IW | Slot that completed |
| issue_ok | output | DEPTH | Per-slot issue-eligible bits |

DEPTH = LQ_CAP + SQ_CAP, IW = clog2(DEPTH).

## Verification
The bench builds the block with a load capacity of 3 and a store capacity of 2, so the ring has five slots. Five is not a power of two, so the slot counter wraps at a value the pointer width does not supply by itself. Completion slots 5 to 7 are in range of the port but out of range of the ring, which exercises the ignore path. Both full flags are reached within a few allocations, and the release of the oldest entry can coincide with an allocation or a completion. That brings capacity return, wrap-around of the ring and barrier release at the oldest position into frequent contact with the mixed random traffic.

// File: rtl/mq_pkg.sv
package mq_pkg;
  typedef enum logic [1:0] {
    MK_LOAD  = 2'd0,
    MK_STORE = 2'd1,
    MK_LBAR  = 2'd2,
    MK_SBAR  = 2'd3
  } mem_kind_e;

  function automatic logic on_store_side(logic [1:0] k);
    return k[0];
  endfunction

  function automatic logic is_barrier(logic [1:0] k);
    return k[1];
  endfunction
endpackage

// File: rtl/mq_capacity.sv
module mq_capacity #(
  parameter int CAP = 8,
  localparam int CW = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          give,
  output logic [CW-1:0] used,
  output logic          full
);
  always_ff @(posedge clk) begin
    if (rst) used <= '0;
    else     used <= used + CW'(take) - CW'(give);
  end

  assign full = (used == CW'(CAP));

  assert_cap_bound_R2: assert property (@(posedge clk) disable iff (rst)
    used <= CW'(CAP));
  assert_no_take_full_R2: assert property (@(posedge clk) disable iff (rst)
    full && !give |-> !take);
endmodule

// File: rtl/mq_slots.sv
module mq_slots #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  alloc_we,
  input  logic [1:0]            alloc_kind,
  input  logic                  alloc_na,
  input  logic [DEPTH-1:0]      done_set,
  input  logic                  release_head,
  output logic [DEPTH-1:0]      valid_q,
  output logic [DEPTH-1:0][1:0] kind_q,
  output logic [DEPTH-1:0]      na_q,
  output logic [DEPTH-1:0]      done_q,
  output logic [IW-1:0]         head_q,
  output logic [IW-1:0]         tail_q
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (release_head) head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
      if (alloc_we)     tail_q <= (tail_q == LAST) ? '0 : tail_q + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[i] <= 1'b0;
        done_q[i]  <= 1'b0;
        kind_q[i]  <= 2'd0;
        na_q[i]    <= 1'b0;
      end else if (alloc_we && tail_q == IW'(i)) begin
        valid_q[i] <= 1'b1;
        done_q[i]  <= 1'b0;
        kind_q[i]  <= alloc_kind;
        na_q[i]    <= alloc_na;
      end else begin
        if (release_head && head_q == IW'(i)) valid_q[i] <= 1'b0;
        if (done_set[i]) done_q[i] <= 1'b1;
      end
    end
  end

  assert_release_valid_R8: assert property (@(posedge clk) disable iff (rst)
    release_head |-> valid_q[head_q]);
  assert_alloc_free_slot_R2: assert property (@(posedge clk) disable iff (rst)
    alloc_we |-> !valid_q[tail_q]);
endmodule

// File: rtl/mq_rules.sv
module mq_rules
  import mq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                  noalias_mode,
  input  logic [DEPTH-1:0]      valid_q,
  input  logic [DEPTH-1:0][1:0] kind_q,
  input  logic [DEPTH-1:0]      na_q,
  input  logic [DEPTH-1:0]      done_q,
  input  logic [IW-1:0]         head_q,
  output logic [DEPTH-1:0]      elig
);
  int age [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (i >= int'(head_q)) age[i] = i - int'(head_q);
      else                   age[i] = i + DEPTH - int'(head_q);
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (valid_q[j] && age[j] < age[i]) begin
          if (kind_q[i] == MK_LOAD) begin
            if (kind_q[j] == MK_LBAR) blocked = 1'b1;
            if (kind_q[j] == MK_STORE && !done_q[j] && !noalias_mode && !na_q[i])
              blocked = 1'b1;
          end else if (kind_q[i] == MK_STORE) begin
            if (kind_q[j] == MK_SBAR) blocked = 1'b1;
            if (!is_barrier(kind_q[j]) && !done_q[j]) blocked = 1'b1;
          end
        end
      end
      elig[i] = valid_q[i] && !done_q[i] && !is_barrier(kind_q[i]) && !blocked;
    end
  end
endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
  import mq_pkg::*;
#(
  parameter int LQ_CAP = 8,
  parameter int SQ_CAP = 8,
  localparam int DEPTH = LQ_CAP + SQ_CAP,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             noalias_mode,
  input  logic             alloc_valid,
  input  logic [1:0]       alloc_kind,
  input  logic             alloc_noalias,
  output logic [IW-1:0]    alloc_slot,
  output logic             lq_full,
  output logic             sq_full,
  input  logic             cmpl_valid,
  input  logic [IW-1:0]    cmpl_slot,
  output logic [DEPTH-1:0] issue_ok
);
  localparam int LCW = $clog2(LQ_CAP + 1);
  localparam int SCW = $clog2(SQ_CAP + 1);

  logic [DEPTH-1:0]      valid_q, na_q, done_q, done_set;
  logic [DEPTH-1:0][1:0] kind_q;
  logic [IW-1:0]         head_q, tail_q;
  logic [LCW-1:0]        l_used;
  logic [SCW-1:0]        s_used;
  logic                  alloc_ok, cmpl_ok, cmpl_in_range, release_head;
  logic [1:0]            head_kind;

  assign cmpl_in_range = int'(cmpl_slot) < DEPTH;
  assign cmpl_ok  = cmpl_valid && cmpl_in_range && issue_ok[cmpl_slot];
  assign alloc_ok = alloc_valid &&
                    (on_store_side(alloc_kind) ? !sq_full : !lq_full);
  assign head_kind    = kind_q[head_q];
  assign release_head = valid_q[head_q] && (done_q[head_q] || is_barrier(head_kind));
  assign alloc_slot   = tail_q;

  always_comb begin
    done_set = '0;
    if (cmpl_ok) done_set[cmpl_slot] = 1'b1;
  end

  mq_capacity #(.CAP(LQ_CAP)) u_lcap (
    .clk(clk), .rst(rst),
    .take(alloc_ok && !on_store_side(alloc_kind)),
    .give(release_head && !on_store_side(head_kind)),
    .used(l_used), .full(lq_full)
  );

  mq_capacity #(.CAP(SQ_CAP)) u_scap (
    .clk(clk), .rst(rst),
    .take(alloc_ok && on_store_side(alloc_kind)),
    .give(release_head && on_store_side(head_kind)),
    .used(s_used), .full(sq_full)
  );

  mq_slots #(.DEPTH(DEPTH)) u_slots (
    .clk(clk), .rst(rst),
    .alloc_we(alloc_ok), .alloc_kind(alloc_kind), .alloc_na(alloc_noalias),
    .done_set(done_set), .release_head(release_head),
    .valid_q(valid_q), .kind_q(kind_q), .na_q(na_q), .done_q(done_q),
    .head_q(head_q), .tail_q(tail_q)
  );

  mq_rules #(.DEPTH(DEPTH)) u_rules (
    .noalias_mode(noalias_mode),
    .valid_q(valid_q), .kind_q(kind_q), .na_q(na_q), .done_q(done_q),
    .head_q(head_q), .elig(issue_ok)
  );

  logic [DEPTH-1:0] bar_mask;
  always_comb begin
    for (int i = 0; i < DEPTH; i++) bar_mask[i] = valid_q[i] && is_barrier(kind_q[i]);
  end

  assert_no_barrier_issue_R6: assert property (@(posedge clk) disable iff (rst)
    (issue_ok & bar_mask) == '0);
  assert_issue_not_done_R7: assert property (@(posedge clk) disable iff (rst)
    (issue_ok & done_q) == '0);
  assert_head_store_ready_R3: assert property (@(posedge clk) disable iff (rst)
    valid_q[head_q] && head_kind == MK_STORE && !done_q[head_q] |-> issue_ok[head_q]);
  assert_cmpl_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    cmpl_valid && cmpl_in_range && !issue_ok[cmpl_slot] && !done_q[cmpl_slot]
    |=> !done_q[$past(cmpl_slot)]);
  assert_count_matches_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(valid_q) == int'(l_used) + int'(s_used));
endmodule

// File: tb/mem_order_queue_bench.sv
module mem_order_queue_bench;
  localparam int LQ = 3;
  localparam int SQ = 2;
  localparam int D  = LQ + SQ;
  localparam int IW = $clog2(D);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic noalias_mode = 1'b1;
  logic alloc_valid = 1'b0, alloc_noalias = 1'b0, cmpl_valid = 1'b0;
  logic [1:0] alloc_kind = 2'd0;
  logic [IW-1:0] cmpl_slot = '0;
  logic [IW-1:0] alloc_slot;
  logic lq_full, sq_full;
  logic [D-1:0] issue_ok;

  always #5 clk = ~clk;

  mem_order_queue #(.LQ_CAP(LQ), .SQ_CAP(SQ)) u_mem_order_queue (
    .clk(clk), .rst(rst), .noalias_mode(noalias_mode),
    .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_noalias(alloc_noalias),
    .alloc_slot(alloc_slot), .lq_full(lq_full), .sq_full(sq_full),
    .cmpl_valid(cmpl_valid), .cmpl_slot(cmpl_slot), .issue_ok(issue_ok)
  );

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  bit finished = 0;

  // behavioural model: entries oldest first
  int q_slot[$];
  int q_kind[$];
  bit q_na[$];
  bit q_done[$];
  int m_tail = 0;
  bit m_mode = 1;

  function automatic bit m_elig(int p);
    int k = q_kind[p];
    if (q_done[p] || k >= 2) return 0;
    for (int j = 0; j < p; j++) begin
      if (k == 0) begin
        if (q_kind[j] == 2) return 0;
        if (q_kind[j] == 1 && !q_done[j] && !m_mode && !q_na[p]) return 0;
      end else begin
        if (q_kind[j] == 3) return 0;
        if (q_kind[j] < 2 && !q_done[j]) return 0;
      end
    end
    return 1;
  endfunction

  function automatic logic [D-1:0] m_vec();
    logic [D-1:0] v = '0;
    for (int p = 0; p < q_slot.size(); p++) v[q_slot[p]] = m_elig(p);
    return v;
  endfunction

  function automatic int m_used(bit store_side);
    int n = 0;
    for (int p = 0; p < q_kind.size(); p++) if (q_kind[p][0] == store_side) n++;
    return n;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [D-1:0] e = m_vec();
    for (int s = 0; s < D; s++) begin
      string tag = "R8";
      for (int p = 0; p < q_slot.size(); p++)
        if (q_slot[p] == s) begin
          if (q_done[p]) tag = "R7";
          else if (q_kind[p] >= 2) tag = "R6";
          else if (q_kind[p] == 1) tag = "R3";
          else tag = m_mode ? "R4" : "R5";
        end
      chk(issue_ok[s] == e[s], tag, $sformatf("issue_ok[%0d]", s), issue_ok[s], e[s]);
    end
    chk(lq_full == (m_used(0) == LQ), "R2", "lq_full", lq_full, m_used(0) == LQ);
    chk(sq_full == (m_used(1) == SQ), "R2", "sq_full", sq_full, m_used(1) == SQ);
    chk(int'(alloc_slot) == m_tail, "R2", "alloc_slot", alloc_slot, m_tail);
  endtask

  task automatic model_step(bit av, int k, bit na, bit cv, int ci);
    logic [D-1:0] e = m_vec();
    bit acc = av && ((k % 2) ? (m_used(1) < SQ) : (m_used(0) < LQ));
    bit rel = q_slot.size() > 0 && (q_kind[0] >= 2 || q_done[0]);
    if (cv && ci < D && e[ci])
      for (int p = 0; p < q_slot.size(); p++) if (q_slot[p] == ci) q_done[p] = 1;
    if (rel) begin
      void'(q_slot.pop_front()); void'(q_kind.pop_front());
      void'(q_na.pop_front());   void'(q_done.pop_front());
    end
    if (acc) begin
      q_slot.push_back(m_tail); q_kind.push_back(k);
      q_na.push_back(na);       q_done.push_back(0);
      m_tail = (m_tail + 1) % D;
    end
  endtask

  task automatic cyc(bit av, int k, bit na, bit cv, int ci, bit mode);
    alloc_valid = av; alloc_kind = 2'(k); alloc_noalias = na;
    cmpl_valid = cv;  cmpl_slot = IW'(ci); noalias_mode = mode;
    m_mode = mode;
    model_step(av, k, na, cv, ci);
    @(negedge clk);
    compare_all();
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", n_cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(issue_ok == '0, "R1", "issue_ok", issue_ok, 0);
    chk(!lq_full && !sq_full, "R1", "full flags", {lq_full, sq_full}, 0);
    chk(alloc_slot == '0, "R1", "alloc_slot", alloc_slot, 0);
    compare_all();

    // alias policy
    cyc(1, 1, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 0, 1);
    chk(issue_ok == 5'b00011, "R5", "optimistic load", issue_ok, 5'b00011);
    cyc(0, 0, 0, 0, 0, 0);
    chk(issue_ok == 5'b00001, "R5", "load waits store", issue_ok, 5'b00001);
    cyc(1, 0, 1, 0, 0, 0);
    chk(issue_ok == 5'b00101, "R5", "noalias load", issue_ok, 5'b00101);
    cyc(1, 2, 0, 0, 0, 0);
    chk(lq_full == 1'b1, "R2", "lq_full at cap", lq_full, 1);
    cyc(1, 0, 0, 1, 1, 0);
    chk(issue_ok == 5'b00101, "R7", "ignored completion", issue_ok, 5'b00101);
    chk(alloc_slot == 3'd4, "R2", "rejected alloc", alloc_slot, 4);
    cyc(0, 0, 0, 1, 0, 0);
    chk(issue_ok == 5'b00110, "R7", "store done", issue_ok, 5'b00110);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(1, 3, 0, 1, 1, 0);
    chk(issue_ok == 5'b00100, "R7", "load done", issue_ok, 5'b00100);
    cyc(0, 0, 0, 1, 2, 0);
    chk(issue_ok == 5'b00000, "R7", "all done", issue_ok, 0);
    chk(lq_full == 1'b0, "R8", "capacity returned", lq_full, 0);
    repeat (4) cyc(0, 0, 0, 0, 0, 0);
    chk(alloc_slot == 3'd0, "R2", "slot wrap", alloc_slot, 0);
    chk(issue_ok == '0 && !sq_full, "R8", "drained", issue_ok, 0);

    // barriers
    cyc(1, 1, 0, 0, 0, 1);
    cyc(1, 2, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 0, 1);
    chk(issue_ok == 5'b00001, "R6", "load held by barrier", issue_ok, 5'b00001);
    cyc(0, 0, 0, 1, 0, 1);
    chk(issue_ok == 5'b00000, "R6", "barrier pending", issue_ok, 0);
    cyc(0, 0, 0, 0, 0, 1);
    chk(issue_ok == 5'b00000, "R6", "barrier at head", issue_ok, 0);
    cyc(0, 0, 0, 0, 0, 1);
    chk(issue_ok == 5'b00100, "R6", "barrier released", issue_ok, 5'b00100);
    cyc(0, 0, 0, 1, 2, 1);

    // mixed random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [D-1:0] e = m_vec();
      int cand[$];
      int r = $urandom_range(0, 9);
      int k = (r < 4 || r == 9) ? 0 : (r < 7) ? 1 : (r == 7) ? 2 : 3;
      int ci = $urandom_range(0, 7);
      bit mode = m_mode;
      for (int s = 0; s < D; s++) if (e[s]) cand.push_back(s);
      if (cand.size() > 0 && $urandom_range(0, 9) < 7)
        ci = cand[$urandom_range(0, cand.size() - 1)];
      if ($urandom_range(0, 49) == 0) mode = !mode;
      cyc($urandom_range(0, 99) < 55, k, $urandom_range(0, 3) == 0,
          $urandom_range(0, 9) < 6, ci, mode);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule